// File: doc/BRIEF.md
# Calibratable Real-Time Clock Core

This block keeps calendar time (seconds, minutes, hours, weekday, day of month, month and two-digit year) from a slow tick strobe that arrives at the crystal rate, nominally 32,768 ticks per second. A divider turns the ticks into one-second steps. A chain of BCD counters then carries each step through the calendar, with month lengths and leap years handled.

A host reaches the clock through a sixteen-byte register window at the very top of its byte address space. To read a consistent time, the host sets a freeze bit, reads the frozen copy at leisure and then clears the bit. Counting carries on underneath the whole time. To set the time, the host raises a staging bit, writes any subset of the time bytes into holding registers, and drops the bit. All held bytes then load into the counters in a single cycle, and the divider restarts from zero.

For trimming, a calibration bit puts a fixed 512 Hz square wave taken from the divider onto the interrupt pin, so that the crystal error can be measured. A signed trim value then lengthens or shortens the first second of every minute by a number of ticks.

Top module: `rtc_core`

## Requirements
- R1: After reset the control byte (offset 0) reads 0x00, the oscillator byte (offset 8) reads 0x00, the time reads 00:00:00, weekday 1, date 01, month 01, year 00, and irq_o is 0.
- R2: Bit 7 of the oscillator byte is an active-low enable. While it is 1, the divider and all counters hold their values. While it is 0, the seconds advance once every TICK_HZ ticks.
- R3: Time bytes are BCD at offsets 9 (seconds), 10 (minutes), 11 (hours), 12 (weekday), 13 (date), 14 (month) and 15 (year). Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and advance both the weekday (7 wraps to 1) and the date.
- R4: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 28, or after 29 when the year is divisible by 4. Month 12 wraps to 01 and advances the year, which wraps from 99 to 00.
- R5: While bit 0 of the control byte is 1, reads of the time bytes return the values present when the bit was set. Counting continues underneath, so the time read after the bit is cleared includes the seconds that passed.
- R6: Writes to the time bytes take effect only while bit 1 of the control byte is 1. They go to holding registers, which are first loaded with the live time when the bit rises. Clearing the bit moves all holding registers into the counters at once and restarts the divider. When bit 1 is 0, time-byte writes are ignored.
- R7: While bit 2 of the control byte is 1, irq_o is a square wave that is high for TICK_HZ/1024 ticks and low for TICK_HZ/1024 ticks (512 Hz at the nominal rate). While the bit is 0, irq_o stays 0.
- R8: The oscillator byte holds a trim: bits 5:0 give a magnitude, and bit 6 set means the ticks are removed rather than added. The second that starts at a minute rollover lasts TICK_HZ plus or minus that magnitude in ticks. Every other second lasts TICK_HZ ticks.
- R9: The window is decoded only when the upper ADDR_W-4 address bits are all ones. Writes outside the window change nothing and reads there return 0. Offsets 1 to 7 inside the window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe per crystal tick |
| bus_wr | input | 1 | Write strobe for the host bus |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Interrupt pin, which carries the calibration square wave |

## Verification
The bench builds the clock with TICK_HZ = 2048 and ADDR_W = 15, and holds the tick strobe high. One second then takes 2048 clock cycles, so randomly drawn calendar rollovers, including leap and year-end cases, each finish in a few thousand cycles. At this rate the calibration wave has a period of four ticks, short enough to check edge by edge. Trim values of both signs change the measured second length by a few cycles, which the bench counts exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  typedef logic [6:0][7:0] rtc_bytes_t;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_OSC  = 4'h8;
  localparam logic [3:0] OFS_TIME = 4'h9;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICK_HZ = 32768,
  parameter int TRIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              clr,
  input  logic              last_sec,
  input  logic              trim_neg,
  input  logic [TRIM_W-1:0] trim_mag,
  output logic              sec_pulse,
  output logic              sq
);
  localparam int CW     = $clog2(TICK_HZ) + 2;
  localparam int SQ_BIT = $clog2(TICK_HZ) - 10;
  localparam logic [CW-1:0] BASE = CW'(TICK_HZ - 1);
  localparam logic [CW-1:0] MAXC = CW'(TICK_HZ - 1 + (2 ** TRIM_W) - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          armed;
  logic          term;

  always_comb begin
    limit = BASE;
    if (armed) limit = trim_neg ? BASE - CW'(trim_mag) : BASE + CW'(trim_mag);
  end

  assign term      = (cnt >= limit);
  assign sec_pulse = run & tick & term;
  assign sq        = cnt[SQ_BIT];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (run && tick) begin
      if (term) begin
        cnt   <= '0;
        armed <= last_sec;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));

  // R8
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAXC);

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep import rtc_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now,
  output logic      last_sec
);
  rtc_time_t nxt;

  assign last_sec = (now.sec >= 8'h59);

  always_comb begin
    nxt = now;
    if (now.sec >= 8'h59) begin
      nxt.sec = 8'h00;
      if (now.min >= 8'h59) begin
        nxt.min = 8'h00;
        if (now.hour >= 8'h23) begin
          nxt.hour = 8'h00;
          nxt.day  = (now.day >= 8'h07) ? 8'h01 : now.day + 8'h01;
          if (now.date >= last_date(now.month, now.year)) begin
            nxt.date = 8'h01;
            if (now.month >= 8'h12) begin
              nxt.month = 8'h01;
              nxt.year  = (now.year >= 8'h99) ? 8'h00 : bcd_inc(now.year);
            end else begin
              nxt.month = bcd_inc(now.month);
            end
          end else begin
            nxt.date = bcd_inc(now.date);
          end
        end else begin
          nxt.hour = bcd_inc(now.hour);
        end
      end else begin
        nxt.min = bcd_inc(now.min);
      end
    end else begin
      nxt.sec = bcd_inc(now.sec);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '{year: 8'h00, month: 8'h01, date: 8'h01, day: 8'h01,
               hour: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (load) begin
      now <= load_val;
    end else if (step) begin
      now <= nxt;
    end
  end

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (now == $past(load_val)));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load && now.sec >= 8'h59) |=> (now.sec == 8'h00));

endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
  parameter int TICK_HZ = 32768,
  parameter int ADDR_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o
);
  localparam int OFS_W  = 4;
  localparam int NBYTES = 7;

  logic             win_hit, wr_ok, ctl_wr, osc_wr, time_sel, load_now;
  logic [OFS_W-1:0] ofs;
  logic [2:0]       tidx;
  logic             r_bit, w_bit, cal_bit;
  logic [7:0]       osc_reg;
  logic             sec_pulse, sq, last_sec;
  rtc_time_t        live;
  rtc_bytes_t       live_b, shadow, snap;

  assign win_hit  = &bus_addr[ADDR_W-1:OFS_W];
  assign ofs      = bus_addr[OFS_W-1:0];
  assign wr_ok    = bus_wr & win_hit;
  assign ctl_wr   = wr_ok && (ofs == OFS_CTRL);
  assign osc_wr   = wr_ok && (ofs == OFS_OSC);
  assign time_sel = (ofs >= OFS_TIME);
  assign tidx     = 3'(ofs - OFS_TIME);
  assign load_now = ctl_wr && w_bit && !bus_wdata[1];
  assign live_b   = live;

  rtc_divider #(.TICK_HZ(TICK_HZ), .TRIM_W(6)) u_div (
    .clk(clk), .rst(rst), .tick(tick_32k), .run(!osc_reg[7]), .clr(load_now),
    .last_sec(last_sec), .trim_neg(osc_reg[6]), .trim_mag(osc_reg[5:0]),
    .sec_pulse(sec_pulse), .sq(sq)
  );

  rtc_timekeep u_tk (
    .clk(clk), .rst(rst), .step(sec_pulse), .load(load_now),
    .load_val(rtc_time_t'(shadow)), .now(live), .last_sec(last_sec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r_bit   <= 1'b0;
      w_bit   <= 1'b0;
      cal_bit <= 1'b0;
      osc_reg <= 8'h00;
    end else begin
      if (ctl_wr) begin
        r_bit   <= bus_wdata[0];
        w_bit   <= bus_wdata[1];
        cal_bit <= bus_wdata[2];
      end
      if (osc_wr) osc_reg <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (ctl_wr && !w_bit && bus_wdata[1]) begin
      shadow <= live_b;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (wr_ok && w_bit && time_sel && (tidx == 3'(i))) shadow[i] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         snap <= '0;
    else if (!r_bit) snap <= live_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= cal_bit & sq;
      if (!win_hit)             bus_rdata <= 8'h00;
      else if (ofs == OFS_CTRL) bus_rdata <= {5'b0, cal_bit, w_bit, r_bit};
      else if (ofs == OFS_OSC)  bus_rdata <= osc_reg;
      else if (time_sel)        bus_rdata <= snap[tidx];
      else                      bus_rdata <= 8'h00;
    end
  end

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (r_bit && $past(r_bit)) |-> $stable(snap));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cal_bit |=> !irq_o);

  // R9
  win_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !win_hit) |=> ($stable(osc_reg) && $stable(w_bit)));

endmodule

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;
  localparam int HZ = 2048;
  localparam logic [14:0] BASE = 15'h7FF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic bus_wr = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_o;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rtc_core #(.TICK_HZ(HZ), .ADDR_W(15)) u0 (
    .clk(clk), .rst(rst), .tick_32k(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk); #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  // time as ints: [0]=sec [1]=min [2]=hour [3]=day [4]=date [5]=month [6]=year
  function automatic logic [55:0] pack_t(input int t[7]);
    logic [55:0] r;
    for (int i = 0; i < 7; i++) r[i*8 +: 8] = bcd(t[i]);
    return r;
  endfunction

  task automatic set_time(input int t[7]);
    wr(BASE, 8'h02);
    for (int i = 0; i < 7; i++) wr(BASE + 15'(9 + i), bcd(t[i]));
    wr(BASE, 8'h00);
  endtask

  task automatic read_time(output logic [55:0] r);
    logic [7:0] b;
    wr(BASE, 8'h01);
    for (int i = 0; i < 7; i++) begin
      rd(BASE + 15'(9 + i), b);
      r[i*8 +: 8] = b;
    end
    wr(BASE, 8'h00);
  endtask

  function automatic void next_sec(inout int t[7]);
    t[0]++;
    if (t[0] < 60) return;
    t[0] = 0; t[1]++;
    if (t[1] < 60) return;
    t[1] = 0; t[2]++;
    if (t[2] < 24) return;
    t[2] = 0;
    t[3] = (t[3] == 7) ? 1 : t[3] + 1;
    t[4]++;
    if (t[4] <= dim(t[5], t[6])) return;
    t[4] = 1; t[5]++;
    if (t[5] <= 12) return;
    t[5] = 1; t[6] = (t[6] + 1) % 100;
  endfunction

  task automatic one_step(input int t[7], input string tag);
    logic [55:0] got;
    int e[7];
    e = t;
    set_time(t);
    repeat (HZ + 20) @(negedge clk);
    read_time(got);
    next_sec(e);
    chk(tag, {8'h0, got}, {8'h0, pack_t(e)});
  endtask

  task automatic sec_len(input logic [7:0] osc, input int exp0, input string tag);
    int t[7] = '{59, 0, 0, 1, 1, 1, 0};
    logic [7:0] prev, v;
    int n;
    wr(BASE + 15'd8, osc);
    set_time(t);
    rd(BASE + 15'd9, prev);
    n = 0;
    while (prev == 8'h59 && n < 3 * HZ) begin rd(BASE + 15'd9, prev); n++; end
    n = 0;
    v = prev;
    while (v == prev && n < 3 * HZ) begin rd(BASE + 15'd9, v); n++; end
    chk({tag, " trimmed second"}, 64'(n), 64'(exp0));
    prev = v; n = 0;
    while (v == prev && n < 3 * HZ) begin rd(BASE + 15'd9, v); n++; end
    chk({tag, " plain second"}, 64'(n), 64'(HZ));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [55:0] tm;
    logic s[20];
    int cnt;
    int t[7];
    bit ok;
    void'($urandom(32'd2718));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(BASE, b);          chk("R1 ctrl", 64'(b), 64'h00);
    rd(BASE + 15'd8, b);  chk("R1 osc", 64'(b), 64'h00);
    chk("R1 irq", 64'(irq_o), 64'h0);
    read_time(tm);        chk("R1 time", {8'h0, tm}, 64'h00_00_01_01_01_00_00_00);

    // R3/R4 directed rollovers
    one_step('{59, 59, 23, 7, 28, 2, 24}, "R4 leap feb28");
    one_step('{59, 59, 23, 3, 28, 2, 23}, "R4 plain feb28");
    one_step('{59, 59, 23, 2, 29, 2, 0},  "R4 leap feb29");
    one_step('{59, 59, 23, 5, 31, 12, 99}, "R4 year wrap");
    one_step('{59, 59, 23, 4, 30, 6, 10}, "R4 june30");
    one_step('{59, 59, 9, 4, 15, 6, 10},  "R3 hour carry");

    // R3/R4 random cases
    for (int k = 0; k < 8; k++) begin
      t[5] = $urandom_range(1, 12);
      t[6] = $urandom_range(0, 99);
      t[3] = $urandom_range(1, 7);
      if (k % 2 == 0) begin
        t[0] = 59; t[1] = 59; t[2] = 23; t[4] = dim(t[5], t[6]);
      end else begin
        t[0] = $urandom_range(0, 59); t[1] = $urandom_range(0, 59);
        t[2] = $urandom_range(0, 23); t[4] = $urandom_range(1, dim(t[5], t[6]));
      end
      one_step(t, (k % 2 == 0) ? "R4 random rollover" : "R3 random step");
    end

    // R8 trim both signs
    sec_len(8'h05, HZ + 5, "R8 add5");
    sec_len(8'h47, HZ - 7, "R8 sub7");
    wr(BASE + 15'd8, 8'h00);

    // R5 snapshot frozen while live runs
    set_time('{10, 0, 0, 1, 1, 1, 0});
    wr(BASE, 8'h01);
    repeat (2 * HZ + 10) @(negedge clk);
    rd(BASE + 15'd9, b);  chk("R5 frozen", 64'(b), 64'h10);
    wr(BASE, 8'h00);
    rd(BASE + 15'd9, b);  chk("R5 live kept counting", 64'(b), 64'h12);

    // R7 calibration square wave
    wr(BASE, 8'h04);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20; i++) begin @(negedge clk); s[i] = irq_o; end
    ok = 1; cnt = 0;
    for (int i = 0; i < 18; i++) if (s[i] == s[i+2]) ok = 0;
    for (int i = 0; i < 16; i++) if (s[i]) cnt++;
    chk("R7 half period", 64'(ok), 64'h1);
    chk("R7 duty", 64'(cnt), 64'd8);
    wr(BASE, 8'h00);
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (irq_o) cnt++; end
    chk("R7 quiet", 64'(cnt), 64'd0);

    // R2 oscillator stopped
    wr(BASE + 15'd8, 8'h80);
    set_time('{20, 30, 12, 3, 10, 5, 44});
    repeat (3 * HZ) @(negedge clk);
    read_time(tm);
    chk("R2 halted", {8'h0, tm}, {8'h0, pack_t('{20, 30, 12, 3, 10, 5, 44})});

    // R6 writes ignored without staging, staged writes load together
    wr(BASE + 15'd9, 8'h33);
    rd(BASE + 15'd9, b);  chk("R6 ignored", 64'(b), 64'h20);
    wr(BASE, 8'h02);
    wr(BASE + 15'd10, 8'h45);
    rd(BASE + 15'd10, b); chk("R6 staged hidden", 64'(b), 64'h30);
    wr(BASE, 8'h00);
    read_time(tm);
    chk("R6 loaded", {8'h0, tm}, {8'h0, pack_t('{20, 45, 12, 3, 10, 5, 44})});

    // R9 window decode
    wr(BASE, 8'h02);
    wr(15'h0009, 8'h55);
    wr(BASE, 8'h00);
    rd(BASE + 15'd9, b);  chk("R9 outside write", 64'(b), 64'h20);
    wr(15'h3008, 8'h00);
    rd(BASE + 15'd8, b);  chk("R9 osc untouched", 64'(b), 64'h80);
    rd(15'h0009, b);      chk("R9 outside read", 64'(b), 64'h00);
    rd(BASE + 15'd3, b);  chk("R9 gap read", 64'(b), 64'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule